// File: doc/BRIEF.md
# Dual-Width Capture Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves. A two-bit mode field reshapes it into one of four forms. It can be two independent prescaled 8-bit timers. It can be a prescaled 8-bit timer in the low half paired with an 8-bit event counter in the high half. It can be a single 16-bit prescaled timer, or a single 16-bit event counter. Each counting element reloads to zero when it reaches its match value, and it leaves a sticky flag that drives an interrupt output.

Two capture inputs, A and B, snapshot the whole count into their own 16-bit capture registers on a rising edge. In the 8-bit modes each half reads its own byte of each capture register. In the 16-bit modes, reading the low byte freezes a copy of the high byte, so a two-byte read stays coherent even if a new capture lands between the two reads. All external inputs pass through a two-flop synchronizer before their edges are detected. A simple register port sets the mode, run, prescalers and match values, clears the flags and returns capture data.

Top module: `cap_timer`

## Requirements
- R1: After reset the mode is 0 and run is 0. Both counts, both prescale reloads, both capture registers and both flags are zero, both match registers are 0xFF, and rdata is 0.
- R2: A half that uses a prescaler with reload value P advances once every P+1 clocks while run is set, and holds while run is clear.
- R3: Mode 0 runs two independent 8-bit timers. The low half uses prescaler reload PRE_LO (address 1) and match MAT_LO (address 3). The high half uses PRE_HI (address 2) and MAT_HI (address 4).
- R4: Mode 1 runs the low half as a prescaled 8-bit timer. The high half counts rising edges of evt_in, and only while run is set.
- R5: Mode 2 runs one 16-bit timer clocked by the low prescaler, and the low byte carries into the high byte in the same clock.
- R6: Mode 3 runs one 16-bit counter of evt_in rising edges while run is set.
- R7: A counting element that advances while equal to its match value (a 16-bit pair in modes 2 and 3) reloads to 0 and sets its flag. The flags are bit 0 (low half), which only the 8-bit modes set, and bit 1 (high half, or the whole 16-bit counter). Both flags are sticky. Writing 1 to a bit of FLAGS (address 9) clears that flag. irq_lo and irq_hi mirror the two flags.
- R8: A rising edge on cap_a_in latches the current 16-bit count into capture A, and cap_b_in does the same for capture B. The low and high bytes are read at addresses 5/6 (A) and 7/8 (B).
- R9: A CTRL write (address 0; bits 1:0 mode, bit 2 run) whose mode differs from the current one clears both counts and both prescalers. A CTRL write with the same mode only changes run and keeps the count.
- R10: In modes 2 and 3, a read of the high capture byte returns the copy taken at the last read of the matching low byte. In modes 0 and 1 it returns the live byte.
- R11: A read with rd_en returns the addressed register on rdata one clock later: CTRL, PRE_LO/HI, MAT_LO/HI, captures or FLAGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| cap_a_in | input | 1 | Capture A trigger (asynchronous) |
| cap_b_in | input | 1 | Capture B trigger (asynchronous) |
| evt_in | input | 1 | External event input (asynchronous) |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or 16-bit match flag |

## Verification
The timer modes are tried with prescale reloads of 0, 1 and 2 over counted clock windows. These windows separate the reload period from off-by-one errors, and a 300-tick run proves the carry into the high byte. The event modes are driven with bursts of 3 to 600 pulses, which exposes double or missed edge detection. The 16-bit burst also crosses 0xFF, and a small 16-bit match value shows the wrap and the high flag. Capture reads interleaved with new captures show the frozen high byte in the 16-bit mode against the live byte in the mixed mode. Stop writes and mode-change writes show the difference between a hold and a clear.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL8 = 2'd0,
        MODE_MIX8  = 2'd1,
        MODE_TMR16 = 2'd2,
        MODE_EVT16 = 2'd3
    } ctm_mode_e;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_CTRL    = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_PRE_LO  = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_PRE_HI  = REG_AW'(2);
    localparam logic [REG_AW-1:0] RA_MAT_LO  = REG_AW'(3);
    localparam logic [REG_AW-1:0] RA_MAT_HI  = REG_AW'(4);
    localparam logic [REG_AW-1:0] RA_CAPA_LO = REG_AW'(5);
    localparam logic [REG_AW-1:0] RA_CAPA_HI = REG_AW'(6);
    localparam logic [REG_AW-1:0] RA_CAPB_LO = REG_AW'(7);
    localparam logic [REG_AW-1:0] RA_CAPB_HI = REG_AW'(8);
    localparam logic [REG_AW-1:0] RA_FLAGS   = REG_AW'(9);

    function automatic logic mode_is_wide(ctm_mode_e m);
        return (m == MODE_TMR16) || (m == MODE_EVT16);
    endfunction

endpackage

// File: rtl/ctm_edge_sync.sv
module ctm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R8

endmodule

// File: rtl/ctm_prescale.sv
module ctm_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] rld,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == rld);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else if (run)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q)); // R2

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import ctm_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    input  logic              cap_a_in,
    input  logic              cap_b_in,
    input  logic              evt_in,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int N_SYNC = 3;
    localparam int N_PRE  = 2;

    typedef struct packed {
        ctm_mode_e         mode;
        logic              run;
        logic [PRE_W-1:0]  pre_lo;
        logic [PRE_W-1:0]  pre_hi;
        logic [HALF_W-1:0] mat_lo;
        logic [HALF_W-1:0] mat_hi;
        logic [HALF_W-1:0] cnt_lo;
        logic [HALF_W-1:0] cnt_hi;
        logic [FULL_W-1:0] cap_a;
        logic [FULL_W-1:0] cap_b;
        logic [HALF_W-1:0] shd_a;
        logic [HALF_W-1:0] shd_b;
        logic              flg_lo;
        logic              flg_hi;
        logic [HALF_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    // input synchronizers: 0 = capture A, 1 = capture B, 2 = events
    logic [N_SYNC-1:0] raw_in, rise;
    assign raw_in = {evt_in, cap_b_in, cap_a_in};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        ctm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    // prescalers: 0 = low half, 1 = high half
    logic [N_PRE-1:0]            pre_tick;
    logic [N_PRE-1:0][PRE_W-1:0] pre_rld;
    logic                        mode_chg;
    assign pre_rld = {st_q.pre_hi, st_q.pre_lo};

    for (genvar p = 0; p < N_PRE; p++) begin : g_pre
        ctm_prescale #(.PRE_W(PRE_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (mode_chg),
            .run  (st_q.run),
            .rld  (pre_rld[p]),
            .tick (pre_tick[p])
        );
    end

    logic              ctrl_wr, flag_wr, wide, evt_tick, inc_lo, inc_hi;
    logic [FULL_W-1:0] cnt16, mat16;

    always_comb begin
        ctrl_wr  = wr_en && (addr == RA_CTRL);
        flag_wr  = wr_en && (addr == RA_FLAGS);
        mode_chg = ctrl_wr && (ctm_mode_e'(wdata[1:0]) != st_q.mode);
        wide     = mode_is_wide(st_q.mode);
        evt_tick = st_q.run && rise[2];
        inc_lo   = (st_q.mode == MODE_EVT16) ? evt_tick : pre_tick[0];
        inc_hi   = (st_q.mode == MODE_MIX8)  ? evt_tick : pre_tick[1];
        cnt16    = {st_q.cnt_hi, st_q.cnt_lo};
        mat16    = {st_q.mat_hi, st_q.mat_lo};
    end

    always_comb begin
        st_d = st_q;

        // flag clears first, so that a match in the same cycle wins
        if (flag_wr) begin
            if (wdata[0]) st_d.flg_lo = 1'b0;
            if (wdata[1]) st_d.flg_hi = 1'b0;
        end

        // counting
        if (wide) begin
            if (inc_lo) begin
                if (cnt16 == mat16) begin
                    {st_d.cnt_hi, st_d.cnt_lo} = '0;
                    st_d.flg_hi = 1'b1;
                end else begin
                    {st_d.cnt_hi, st_d.cnt_lo} = cnt16 + 1'b1;
                end
            end
        end else begin
            if (inc_lo) begin
                if (st_q.cnt_lo == st_q.mat_lo) begin
                    st_d.cnt_lo = '0;
                    st_d.flg_lo = 1'b1;
                end else begin
                    st_d.cnt_lo = st_q.cnt_lo + 1'b1;
                end
            end
            if (inc_hi) begin
                if (st_q.cnt_hi == st_q.mat_hi) begin
                    st_d.cnt_hi = '0;
                    st_d.flg_hi = 1'b1;
                end else begin
                    st_d.cnt_hi = st_q.cnt_hi + 1'b1;
                end
            end
        end

        // captures
        if (rise[0]) st_d.cap_a = cnt16;
        if (rise[1]) st_d.cap_b = cnt16;

        // register writes
        if (wr_en) begin
            unique case (addr)
                RA_CTRL: begin
                    st_d.mode = ctm_mode_e'(wdata[1:0]);
                    st_d.run  = wdata[2];
                end
                RA_PRE_LO: st_d.pre_lo = wdata[PRE_W-1:0];
                RA_PRE_HI: st_d.pre_hi = wdata[PRE_W-1:0];
                RA_MAT_LO: st_d.mat_lo = wdata;
                RA_MAT_HI: st_d.mat_hi = wdata;
                default: ;
            endcase
        end
        if (mode_chg) begin
            st_d.cnt_lo = '0;
            st_d.cnt_hi = '0;
        end

        // reads
        if (rd_en) begin
            unique case (addr)
                RA_CTRL:    st_d.rdata = HALF_W'({st_q.run, st_q.mode});
                RA_PRE_LO:  st_d.rdata = HALF_W'(st_q.pre_lo);
                RA_PRE_HI:  st_d.rdata = HALF_W'(st_q.pre_hi);
                RA_MAT_LO:  st_d.rdata = st_q.mat_lo;
                RA_MAT_HI:  st_d.rdata = st_q.mat_hi;
                RA_CAPA_LO: begin
                    st_d.rdata = st_q.cap_a[HALF_W-1:0];
                    st_d.shd_a = st_q.cap_a[FULL_W-1:HALF_W];
                end
                RA_CAPA_HI: st_d.rdata = wide ? st_q.shd_a : st_q.cap_a[FULL_W-1:HALF_W];
                RA_CAPB_LO: begin
                    st_d.rdata = st_q.cap_b[HALF_W-1:0];
                    st_d.shd_b = st_q.cap_b[FULL_W-1:HALF_W];
                end
                RA_CAPB_HI: st_d.rdata = wide ? st_q.shd_b : st_q.cap_b[FULL_W-1:HALF_W];
                RA_FLAGS:   st_d.rdata = HALF_W'({st_q.flg_hi, st_q.flg_lo});
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.mat_lo <= '1;
            st_q.mat_hi <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.rdata;
    assign irq_lo = st_q.flg_lo;
    assign irq_hi = st_q.flg_hi;

    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.cnt_lo == '0 && st_q.cnt_hi == '0)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !mode_chg) |=> $stable({st_q.cnt_hi, st_q.cnt_lo})); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flg_lo && !(flag_wr && wdata[0])) |=> st_q.flg_lo); // R7

    AST_WIDE_NO_LO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !st_q.flg_lo) |=> !st_q.flg_lo); // R7

    AST_CAP_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise[0] |=> $stable(st_q.cap_a)); // R8

    AST_NO_EVT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_EVT16 && !st_q.run && !mode_chg) |=> $stable(st_q.cnt_lo)); // R6

endmodule

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
    import ctm_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cap_a_in = 1'b0;
    logic       cap_b_in = 1'b0;
    logic       evt_in = 1'b0;
    logic       irq_lo, irq_hi;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [7:0] exp_q[$];
    bit         use_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_a_in(cap_a_in), .cap_b_in(cap_b_in),
        .evt_in(evt_in), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read result in the cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen === 1'b1) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard actual=0x%0h expected=none", rdata);
            end else begin
                logic [7:0] e;
                bit         u;
                string      t;
                e = exp_q.pop_front();
                u = use_q.pop_front();
                t = tag_q.pop_front();
                if (u) chk(rdata, e, t);
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] e, bit use_it, string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e); use_q.push_back(use_it); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_evt(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_in = 1'b1;
            repeat (2) @(negedge clk);
            evt_in = 1'b0;
            repeat (1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_cap(bit sel_b);
        @(negedge clk);
        if (sel_b) cap_b_in = 1'b1; else cap_a_in = 1'b1;
        repeat (2) @(negedge clk);
        cap_a_in = 1'b0; cap_b_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // start with a clearing CTRL write, wait, then stop with same mode
    task automatic timed_run(logic [1:0] mode, int gap);
        wr(RA_CTRL, {6'd0, ~mode[1], mode[0]});   // different mode, run 0
        wr(RA_CTRL, {5'd0, 1'b1, mode});          // clear + start
        repeat (gap) @(posedge clk);
        wr(RA_CTRL, {5'd0, 1'b0, mode});          // stop, no clear
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({6'd0, irq_hi, irq_lo}, 8'h00, "R1 irq after reset");
        rd(RA_CAPA_LO, 8'h00, 1, "R1 capture A low");
        rd(RA_MAT_LO,  8'hFF, 1, "R1 match low");
        rd(RA_MAT_HI,  8'hFF, 1, "R1 match high");
        rd(RA_FLAGS,   8'h00, 1, "R1 flags");
        rd(RA_CTRL,    8'h00, 1, "R1 ctrl");
        rd(RA_PRE_LO,  8'h00, 1, "R11 prescale low readback");

        // R5 mode 2, prescale 0, ten ticks
        wr(RA_PRE_LO, 8'd0);
        timed_run(2'd2, 9);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'd10, 1, "R5 timer16 low");
        rd(RA_CAPA_HI, 8'd0,  1, "R5 timer16 high");

        // R2 prescale 2: three ticks in ten clocks
        wr(RA_PRE_LO, 8'd2);
        timed_run(2'd2, 9);
        pulse_cap(1);
        rd(RA_CAPB_LO, 8'd3, 1, "R2 prescale 2 count");
        rd(RA_CAPB_HI, 8'd0, 1, "R8 capture B high");

        // R5 carry: 300 ticks
        wr(RA_PRE_LO, 8'd0);
        timed_run(2'd2, 299);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'h2C, 1, "R5 carry low");
        rd(RA_CAPA_HI, 8'h01, 1, "R5 carry high");
        chk({6'd0, irq_hi, irq_lo}, 8'h00, "R7 no flag below match");

        // R3 mode 0 independent halves
        wr(RA_PRE_HI, 8'd1);
        wr(RA_MAT_LO, 8'd4);
        wr(RA_MAT_HI, 8'd200);
        timed_run(2'd0, 9);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'd0, 1, "R3 low wrapped at match");
        rd(RA_CAPA_HI, 8'd5, 1, "R3 high prescale 1");
        rd(RA_FLAGS, 8'h01, 1, "R7 low flag only");
        @(negedge clk);
        chk({6'd0, irq_hi, irq_lo}, 8'h01, "R7 irq_lo");
        wr(RA_FLAGS, 8'h01);
        rd(RA_FLAGS, 8'h00, 1, "R7 write-1 clear");

        // R6 / R10 mode 3 events with frozen high byte
        wr(RA_CTRL, 8'h07);
        pulse_evt(300);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'h2C, 1, "R6 events 300 low");
        pulse_evt(300);
        pulse_cap(0);
        rd(RA_CAPA_HI, 8'h01, 1, "R10 frozen high byte");
        rd(RA_CAPA_LO, 8'h58, 1, "R6 events 600 low");
        rd(RA_CAPA_HI, 8'h02, 1, "R6 events 600 high");

        // R9 stop holds count, events ignored
        wr(RA_CTRL, 8'h03);
        pulse_evt(5);
        pulse_cap(1);
        rd(RA_CAPB_LO, 8'h58, 1, "R9 stopped low held");
        rd(RA_CAPB_HI, 8'h02, 1, "R9 stopped high held");

        // R7 16-bit match wraps and sets high flag
        wr(RA_MAT_LO, 8'd5);
        wr(RA_MAT_HI, 8'd0);
        wr(RA_CTRL, 8'h00);
        wr(RA_CTRL, 8'h07);
        pulse_evt(8);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'd2, 1, "R7 16-bit wrap low");
        rd(RA_CAPA_HI, 8'd0, 1, "R7 16-bit wrap high");
        rd(RA_FLAGS, 8'h02, 1, "R7 16-bit sets high flag");
        @(negedge clk);
        chk({6'd0, irq_hi, irq_lo}, 8'h02, "R7 irq_hi");

        // R4 / R10 mode 1: high half counts events, live high byte
        wr(RA_FLAGS, 8'h03);
        wr(RA_MAT_LO, 8'hFF);
        wr(RA_MAT_HI, 8'hFF);
        wr(RA_CTRL, 8'h05);
        pulse_evt(3);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'h00, 0, "R4 low free-running");
        pulse_evt(2);
        pulse_cap(0);
        rd(RA_CAPA_HI, 8'd5, 1, "R4 R10 live high in mode 1");

        // R9 mode change clears
        wr(RA_CTRL, 8'h02);
        pulse_cap(0);
        rd(RA_CAPA_LO, 8'd0, 1, "R9 clear low");
        rd(RA_CAPA_HI, 8'd0, 1, "R9 clear high");

        // R11 register readback
        wr(RA_PRE_HI, 8'h5A);
        rd(RA_PRE_HI, 8'h5A, 1, "R11 prescale high readback");
        rd(RA_CTRL,   8'h02, 1, "R11 ctrl readback");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule